// File: doc/BRIEF.md
# Clock Generator Recovery Watchdog

This block guards a frequency change on a clock generator. Software programs an interval in half-second units and arms the watchdog before it moves the clock to a new frequency code. If software does not disarm it before the interval runs out, the block drives an active-low reset pulse that lasts one half-second tick. It also moves the active frequency select away from the code that failed.

Recovery escalates in two stages. The first expiry moves the output select from the programmed target code to a programmed fallback code. If the system fails again while it runs on that fallback code, the next expiry moves the select to the board strap code and keeps it there. The recovery stage survives the reset pulse it produces. Only the power-on reset clears it. A prescaler divides the reference clock into half-second ticks, and a parameter sets how many reference cycles make one tick.

The register fields and the strap code are plain level inputs. The outputs are the reset pulse and the active 5-bit frequency select. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `clkgen_watchdog`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wd_reset_n` is 1 and `freq_sel` equals `target_code`.
- R2: Let `wd_enable` be 1 and `wd_interval` be N, with N nonzero. The first falling edge of `wd_reset_n` then comes exactly N*TICK_CYCLES clock cycles after the watchdog is armed.
- R3: Each reset pulse holds `wd_reset_n` at 0 for exactly TICK_CYCLES clock cycles.
- R4: The first expiry after power-on reset makes `freq_sel` equal `fallback_code`. It does so in the same cycle that `wd_reset_n` falls.
- R5: The second expiry makes `freq_sel` equal `strap_code`, and any later expiry leaves it at `strap_code`.
- R6: A `wd_interval` of 0 disarms the watchdog, and it never fires.
- R7: Clearing `wd_enable` clears the tick count. Setting it again restarts the full N*TICK_CYCLES count from zero.
- R8: When a pulse ends and the watchdog is still armed, counting restarts from zero. The next expiry comes N*TICK_CYCLES cycles after `wd_reset_n` rises.
- R9: The recovery stage only changes on an expiry and on power-on reset. Asserting `rst_n` returns `freq_sel` to `target_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| wd_enable | input | 1 | Arms the watchdog when 1 |
| wd_interval | input | 6 | Timeout in half-second ticks; 0 disarms |
| target_code | input | 5 | Frequency code used in the normal stage |
| fallback_code | input | 5 | Frequency code used after the first expiry |
| strap_code | input | 5 | Board jumper frequency code used after the second expiry |
| wd_reset_n | output | 1 | Active-low system reset pulse |
| freq_sel | output | 5 | Active frequency select code |

## Verification
The bench builds the block with TICK_CYCLES set to 4. At that value even the largest interval, 63 ticks, expires in 252 cycles. This keeps exact cycle counts practical for every timeout in the vector table and for the full escalation through both recovery stages. The default parameter value matches a 14.318 MHz reference and only sizes the prescaler counter.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [1:0] {
    STG_NORMAL   = 2'd0,
    STG_FALLBACK = 2'd1,
    STG_STRAP    = 2'd2
  } stage_t;
endpackage

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
  parameter int unsigned TICK_CYCLES = 7159090
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (!run)     pre_q <= '0;
    else if (tick)     pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wd_interval_cnt.sv
module wd_interval_cnt #(
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [IW-1:0] limit,
  output logic          expire
);
  logic [IW-1:0] cnt_q;
  logic [IW:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  assign expire   = run && tick && (next_cnt == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (expire)  cnt_q <= '0;
    else if (tick)    cnt_q <= next_cnt[IW-1:0];
  end
endmodule

// File: rtl/wd_pulse.sv
module wd_pulse #(
  parameter int unsigned LEN = 7159090
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int unsigned LW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [LW-1:0] LAST = LW'(LEN - 1);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      len_q <= '0;
    end else if (fire && !busy) begin
      busy  <= 1'b1;
      len_q <= '0;
    end else if (busy) begin
      if (len_q == LAST) busy <= 1'b0;
      else               len_q <= len_q + 1'b1;
    end
  end
endmodule

// File: rtl/wd_stage.sv
module wd_stage
  import wd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  output stage_t stage
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= STG_NORMAL;
    else if (advance) begin
      unique case (stage)
        STG_NORMAL:   stage <= STG_FALLBACK;
        STG_FALLBACK: stage <= STG_STRAP;
        default:      stage <= STG_STRAP;
      endcase
    end
  end
endmodule

// File: rtl/clkgen_watchdog.sv
module clkgen_watchdog
  import wd_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 7159090,
  parameter int unsigned IW          = 6,
  parameter int unsigned CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_enable,
  input  logic [IW-1:0] wd_interval,
  input  logic [CW-1:0] target_code,
  input  logic [CW-1:0] fallback_code,
  input  logic [CW-1:0] strap_code,
  output logic          wd_reset_n,
  output logic [CW-1:0] freq_sel
);
  logic   pulsing;
  logic   armed;
  logic   tick;
  logic   expire;
  stage_t stage_q;

  assign armed = wd_enable && (wd_interval != '0) && !pulsing;

  wd_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(armed), .tick(tick)
  );

  wd_interval_cnt #(.IW(IW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(armed), .tick(tick),
    .limit(wd_interval), .expire(expire)
  );

  wd_pulse #(.LEN(TICK_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .busy(pulsing)
  );

  wd_stage u_stage (
    .clk(clk), .rst_n(rst_n), .advance(expire), .stage(stage_q)
  );

  assign wd_reset_n = !pulsing;

  always_comb begin
    unique case (stage_q)
      STG_FALLBACK: freq_sel = fallback_code;
      STG_STRAP:    freq_sel = strap_code;
      default:      freq_sel = target_code;
    endcase
  end
endmodule

// File: rtl/wd_checker.sv
module wd_checker
  import wd_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 7159090,
  parameter int unsigned IW          = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wd_reset_n,
  input logic          wd_enable,
  input logic [IW-1:0] wd_interval,
  input stage_t        stage
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_cnt <= '0;
    else if (!wd_reset_n) low_cnt <= low_cnt + 1;
    else                  low_cnt <= '0;
  end

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset_n) |-> (low_cnt == TICK_CYCLES));

  p_fire_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_reset_n) |-> ($past(wd_enable) && ($past(wd_interval) != '0)));

  p_first_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wd_reset_n) && ($past(stage) == STG_NORMAL)) |-> (stage == STG_FALLBACK));

  p_second_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wd_reset_n) && ($past(stage) != STG_NORMAL)) |-> (stage == STG_STRAP));

  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(wd_reset_n) |-> $stable(stage));
endmodule

bind clkgen_watchdog wd_checker #(.TICK_CYCLES(TICK_CYCLES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_reset_n(wd_reset_n),
  .wd_enable(wd_enable), .wd_interval(wd_interval), .stage(stage_q)
);

// File: tb/clkgen_watchdog_test.sv
module clkgen_watchdog_test;
  localparam int unsigned T = 4;
  localparam logic [4:0] TGT = 5'h03;
  localparam logic [4:0] FBK = 5'h11;
  localparam logic [4:0] STR = 5'h1C;
  localparam int NV = 4;
  localparam logic [5:0] IVALS [NV] = '{6'd1, 6'd2, 6'd5, 6'd63};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_enable = 1'b0;
  logic [5:0] wd_interval = '0;
  logic [4:0] target_code = TGT;
  logic [4:0] fallback_code = FBK;
  logic [4:0] strap_code = STR;
  logic wd_reset_n;
  logic [4:0] freq_sel;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  clkgen_watchdog #(.TICK_CYCLES(T)) uut (
    .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .wd_interval(wd_interval),
    .target_code(target_code), .fallback_code(fallback_code),
    .strap_code(strap_code), .wd_reset_n(wd_reset_n), .freq_sel(freq_sel)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wd_enable = 1'b0;
    wd_interval = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      n = n + 1;
      if (!wd_reset_n) break;
    end
  endtask

  task automatic wait_rise(output int w);
    w = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      w = w + 1;
      if (wd_reset_n) break;
    end
  endtask

  initial begin
    int n;
    int w;
    // R1: reset state
    @(negedge clk);
    check(wd_reset_n == 1'b1, "R1", int'(wd_reset_n), 1);
    check(freq_sel == TGT, "R1", int'(freq_sel), int'(TGT));

    // Table of intervals: timing (R2), width (R3), first stage (R4)
    for (int v = 0; v < NV; v++) begin
      do_reset();
      check(freq_sel == TGT, "R1", int'(freq_sel), int'(TGT));
      wd_interval = IVALS[v];
      wd_enable = 1'b1;
      wait_fall(n);
      check(n == int'(IVALS[v]) * T, "R2", n, int'(IVALS[v]) * T);
      check(freq_sel == FBK, "R4", int'(freq_sel), int'(FBK));
      wait_rise(w);
      check(w == T, "R3", w, T);
      check(freq_sel == FBK, "R9", int'(freq_sel), int'(FBK));
    end

    // R5 and R8: escalation and restart after pulse
    do_reset();
    wd_interval = 6'd3;
    wd_enable = 1'b1;
    wait_fall(n);
    wait_rise(w);
    wait_fall(n);
    check(n == 3 * T, "R8", n, 3 * T);
    check(freq_sel == STR, "R5", int'(freq_sel), int'(STR));
    wait_rise(w);
    check(w == T, "R3", w, T);
    wait_fall(n);
    check(freq_sel == STR, "R5", int'(freq_sel), int'(STR));
    wait_rise(w);

    // R9: power-on reset clears stage
    do_reset();
    @(negedge clk);
    check(freq_sel == TGT, "R9", int'(freq_sel), int'(TGT));

    // R6: interval zero never fires
    wd_interval = 6'd0;
    wd_enable = 1'b1;
    w = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (!wd_reset_n) w = w + 1;
    end
    check(w == 0, "R6", w, 0);
    check(freq_sel == TGT, "R6", int'(freq_sel), int'(TGT));

    // R7: disable clears the count
    @(negedge clk);
    wd_enable = 1'b0;
    wd_interval = 6'd4;
    @(negedge clk);
    wd_enable = 1'b1;
    repeat (3 * T + 2) @(negedge clk);
    check(wd_reset_n == 1'b1, "R7", int'(wd_reset_n), 1);
    wd_enable = 1'b0;
    repeat (3) @(negedge clk);
    wd_enable = 1'b1;
    wait_fall(n);
    check(n == 4 * T, "R7", n, 4 * T);
    check(freq_sel == FBK, "R4", int'(freq_sel), int'(FBK));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule